// File: doc/BRIEF.md
# Descriptor Ring Last-Pointer Controller

This block drives one direction of a DMA engine from a circular table of 128 descriptors. Host software hands work over by writing a descriptor ID into a last-pointer register. The engine then steps forward from its current position through every descriptor up to and including that ID. The index wraps from 127 to 0. Each new write moves the target further along the ring and never takes back work that an earlier write granted. A sequence such as 63 then 127, or 127 then a wrapped ID, is therefore processed as one continuous walk.

For each descriptor the block reads the source address, destination address and length (in DWORDs) from a combinational lookup port. It offers these to a data mover with a valid/ready handshake and waits for the mover's one-cycle done pulse. It then pulses a status write-back strobe carrying that descriptor's index, which an external table uses to set the descriptor's DONE bit. A single interrupt request pulse marks the point where the descriptor named by the latest last pointer has finished. Because the interrupt may be shared with the engine of the other direction, software separates the two sources by polling the DONE bits.

Top module: `desc_ring_ctrl`

## Requirements
- R1: After reset the current ID is 127. No mover request, no status write and no interrupt occur until a last pointer is written, and `desc_idx` shows 0, the first descriptor to be processed.
- R2: Writing ID N (pulse `lp_wr` with `lp_id` = N) makes the engine present descriptors current+1 through N to the mover, in ascending order, each exactly once.
- R3: Writes in back-to-back cycles (for example 63, then 127) extend the pending range. Every descriptor up to the newest ID is processed, and none granted earlier is skipped.
- R4: The descriptor index wraps from 127 to 0. Writing 127 and then a smaller ID continues the walk through 0 up to that ID.
- R5: While `mov_valid` is high, `mov_src`, `mov_dst` and `mov_len` carry the lookup values for index `desc_idx`. They and the index stay unchanged until `mov_ready` is seen.
- R6: `mov_len` equals `desc_len` when that is at most 262144 DWORDs (1 MB), and is clamped to 262144 otherwise.
- R7: For each descriptor, `st_we` pulses for one cycle, with `st_idx` equal to its index, in the cycle after the mover's `mov_done` pulse. Status writes follow strict descriptor order.
- R8: `irq` pulses for one cycle, one cycle after the status write of the descriptor that equals the latest last pointer. It does not pulse after any other descriptor.
- R9: A last-pointer write that arrives while the engine is busy, including one in the same cycle as the status write of the old target, moves the target at once. The walk continues without an interrupt at the old target.
- R10: Writing the current ID as the last pointer starts no work: no mover request, no status write and no interrupt follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lp_wr | input | 1 | Last-pointer write strobe |
| lp_id | input | ID_W (7) | Descriptor ID written to the last pointer |
| desc_idx | output | ID_W (7) | Index of the descriptor being looked up (current+1) |
| desc_src | input | AW (32) | Source address of descriptor `desc_idx` |
| desc_dst | input | AW (32) | Destination address of descriptor `desc_idx` |
| desc_len | input | LW (24) | Length in DWORDs of descriptor `desc_idx` |
| mov_valid | output | 1 | Transfer request valid |
| mov_ready | input | 1 | Mover accepts the request |
| mov_src | output | AW (32) | Transfer source address |
| mov_dst | output | AW (32) | Transfer destination address |
| mov_len | output | LW (24) | Transfer length in DWORDs, clamped |
| mov_done | input | 1 | One-cycle pulse when the accepted transfer is complete |
| st_we | output | 1 | Status write-back strobe (sets DONE) |
| st_idx | output | ID_W (7) | Descriptor index for the status write |
| irq | output | 1 | One-cycle completion interrupt request |

## Verification
Two events can fall in the same cycle: the status write of the descriptor that is the current target, and a host write that moves the target further. The bench waits for the status write of the old target. At that same falling edge it drives a new last pointer, so that both land on one clock edge. It then checks that no interrupt follows the old target and that the walk continues to the new ID. There, exactly one interrupt is raised, and the status writes stay in order.

// File: rtl/desc_ring_ctrl.sv
`timescale 1ns/1ps
module desc_ring_ctrl #(
  parameter int ID_W   = 7,
  parameter int AW     = 32,
  parameter int LW     = 24,
  parameter int MAX_DW = 262144
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lp_wr,
  input  logic [ID_W-1:0] lp_id,
  output logic [ID_W-1:0] desc_idx,
  input  logic [AW-1:0]   desc_src,
  input  logic [AW-1:0]   desc_dst,
  input  logic [LW-1:0]   desc_len,
  output logic            mov_valid,
  input  logic            mov_ready,
  output logic [AW-1:0]   mov_src,
  output logic [AW-1:0]   mov_dst,
  output logic [LW-1:0]   mov_len,
  input  logic            mov_done,
  output logic            st_we,
  output logic [ID_W-1:0] st_idx,
  output logic            irq
);
  localparam logic [LW-1:0] LEN_CAP = LW'(MAX_DW);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_WB} state_t;

  state_t          state;
  logic [ID_W-1:0] cur_id, last_id;

  wire [ID_W-1:0] nxt_id  = cur_id + 1'b1;
  wire [ID_W-1:0] last_nx = lp_wr ? lp_id : last_id;
  wire            at_end  = (nxt_id == last_nx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cur_id  <= '1;
      last_id <= '1;
      irq     <= 1'b0;
    end else begin
      last_id <= last_nx;
      irq     <= 1'b0;
      case (state)
        S_IDLE: if (cur_id != last_id) state <= S_REQ;
        S_REQ:  if (mov_ready)         state <= S_WAIT;
        S_WAIT: if (mov_done)          state <= S_WB;
        S_WB: begin
          cur_id <= nxt_id;
          irq    <= at_end;
          state  <= at_end ? S_IDLE : S_REQ;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign desc_idx  = nxt_id;
  assign mov_valid = (state == S_REQ);
  assign mov_src   = desc_src;
  assign mov_dst   = desc_dst;
  assign mov_len   = (desc_len > LEN_CAP) ? LEN_CAP : desc_len;
  assign st_we     = (state == S_WB);
  assign st_idx    = nxt_id;
endmodule

// File: rtl/desc_ring_chk.sv
`timescale 1ns/1ps
module desc_ring_chk #(
  parameter int ID_W   = 7,
  parameter int LW     = 24,
  parameter int MAX_DW = 262144
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mov_valid,
  input logic            mov_ready,
  input logic [ID_W-1:0] desc_idx,
  input logic [LW-1:0]   mov_len,
  input logic            mov_done,
  input logic            st_we,
  input logic            irq
);
  // R5
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mov_valid && !mov_ready |=> mov_valid && $stable(desc_idx));

  // R6
  len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mov_valid |-> mov_len <= LW'(MAX_DW));

  // R7
  wb_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |-> $past(mov_done));

  // R7
  wb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |=> !st_we);

  // R8
  irq_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(st_we));

  // R8
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
endmodule

bind desc_ring_ctrl desc_ring_chk #(.ID_W(ID_W), .LW(LW), .MAX_DW(MAX_DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mov_valid(mov_valid), .mov_ready(mov_ready),
  .desc_idx(desc_idx), .mov_len(mov_len), .mov_done(mov_done),
  .st_we(st_we), .irq(irq)
);

// File: tb/sim_desc_ring_ctrl.sv
`timescale 1ns/1ps
module sim_desc_ring_ctrl;
  localparam int CAP = 262144;

  logic clk = 0, rst_n = 0;
  logic lp_wr = 0;
  logic [6:0] lp_id = 0;
  logic [6:0] desc_idx, st_idx;
  logic [31:0] desc_src, desc_dst, mov_src, mov_dst;
  logic [23:0] desc_len, mov_len;
  logic mov_valid, mov_ready = 0, mov_done = 0, st_we, irq;

  always #2.5 clk = ~clk;

  logic [23:0] len_tab [128];
  assign desc_src = 32'h1000_0000 + (32'(desc_idx) << 12);
  assign desc_dst = 32'h8000_0000 + 32'(desc_idx) * 64;
  assign desc_len = len_tab[desc_idx];

  desc_ring_ctrl u0 (.*);

  int n_chk = 0, n_fail = 0;
  int req_cnt = 0, done_cnt = 0, irq_cnt = 0;
  logic [6:0] exp_req = 0, exp_st = 0, tgt = 127, last_st = 127;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // mover model and request checks
  initial begin
    forever begin
      @(negedge clk);
      if (mov_valid && rst_n) begin
        longint el;
        el = (len_tab[exp_req] > CAP) ? CAP : len_tab[exp_req];
        chk(desc_idx == exp_req, "R2 order", desc_idx, exp_req);
        chk(mov_src == 32'h1000_0000 + (32'(exp_req) << 12), "R5 src", mov_src, 0);
        chk(mov_dst == 32'h8000_0000 + 32'(exp_req) * 64, "R5 dst", mov_dst, 0);
        chk(mov_len == el, "R6 len", mov_len, el);
        exp_req++;
        req_cnt++;
        repeat (req_cnt % 3) @(negedge clk);
        mov_ready = 1;
        @(negedge clk);
        mov_ready = 0;
        repeat (req_cnt % 4) @(negedge clk);
        mov_done = 1;
        @(negedge clk);
        mov_done = 0;
      end
    end
  end

  // status and interrupt monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && st_we) begin
        chk(st_idx == exp_st, "R7 order", st_idx, exp_st);
        last_st = st_idx;
        exp_st++;
        done_cnt++;
      end
      if (rst_n && irq) begin
        irq_cnt++;
        chk(last_st == tgt, "R8 irq point", last_st, tgt);
      end
    end
  end

  task automatic write_lp(input logic [6:0] id);
    @(negedge clk);
    lp_wr = 1; lp_id = id; tgt = id;
    @(negedge clk);
    lp_wr = 0;
  endtask

  task automatic wait_done(input int n);
    for (int i = 0; i < 6000 && done_cnt < n; i++) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(mov_valid == 0, "R1 no request", mov_valid, 0);
    chk(st_we == 0 && irq == 0, "R1 quiet", {st_we, irq}, 0);
    chk(desc_idx == 0, "R1 first index", desc_idx, 0);
  endtask

  task automatic t_single();
    int d0 = done_cnt, i0 = irq_cnt;
    write_lp(3);
    wait_done(d0 + 4);
    chk(done_cnt == d0 + 4, "R2 count", done_cnt - d0, 4);
    chk(irq_cnt == i0 + 1, "R8 one irq", irq_cnt - i0, 1);
  endtask

  task automatic t_clamp();
    int d0 = done_cnt;
    len_tab[4] = 24'hFF_FFFF;
    len_tab[5] = 24'(CAP);
    len_tab[6] = 24'(CAP + 1);
    write_lp(6);
    wait_done(d0 + 3);
    chk(done_cnt == d0 + 3, "R6 count", done_cnt - d0, 3);
  endtask

  task automatic t_burst();
    int d0 = done_cnt, i0 = irq_cnt;
    @(negedge clk);
    lp_wr = 1; lp_id = 63; tgt = 63;
    @(negedge clk);
    lp_id = 127; tgt = 127;
    @(negedge clk);
    lp_wr = 0;
    wait_done(d0 + 121);
    chk(done_cnt == d0 + 121, "R3 all granted done", done_cnt - d0, 121);
    chk(irq_cnt == i0 + 1, "R3 single irq", irq_cnt - i0, 1);
    chk(last_st == 127, "R3 last", last_st, 127);
  endtask

  task automatic t_wrap();
    int d0, i0;
    write_lp(100);
    wait_done(done_cnt + 101);
    d0 = done_cnt; i0 = irq_cnt;
    @(negedge clk);
    lp_wr = 1; lp_id = 127; tgt = 127;
    @(negedge clk);
    lp_id = 5; tgt = 5;
    @(negedge clk);
    lp_wr = 0;
    wait_done(d0 + 33);
    chk(done_cnt == d0 + 33, "R4 wrap count", done_cnt - d0, 33);
    chk(last_st == 5, "R4 wrap end", last_st, 5);
    chk(irq_cnt == i0 + 1, "R4 irq", irq_cnt - i0, 1);
  endtask

  task automatic t_retarget();
    int d0 = done_cnt, i0 = irq_cnt;
    write_lp(8);
    for (int i = 0; i < 500 && done_cnt == d0; i++) @(negedge clk);
    write_lp(15);
    wait_done(d0 + 10);
    chk(done_cnt == d0 + 10, "R9 busy count", done_cnt - d0, 10);
    chk(irq_cnt == i0 + 1, "R9 busy irq", irq_cnt - i0, 1);
  endtask

  task automatic t_collide();
    int d0 = done_cnt, i0 = irq_cnt;
    write_lp(16);
    for (int i = 0; i < 500 && !(st_we && st_idx == 16); i++) @(negedge clk);
    lp_wr = 1; lp_id = 18; tgt = 18;
    @(negedge clk);
    lp_wr = 0;
    chk(irq == 0, "R9 no irq at old target", irq, 0);
    wait_done(d0 + 3);
    chk(done_cnt == d0 + 3, "R9 collide count", done_cnt - d0, 3);
    chk(irq_cnt == i0 + 1, "R9 collide irq", irq_cnt - i0, 1);
  endtask

  task automatic t_noop();
    int r0 = req_cnt, d0 = done_cnt, i0 = irq_cnt;
    write_lp(18);
    repeat (30) @(negedge clk);
    chk(req_cnt == r0, "R10 no request", req_cnt - r0, 0);
    chk(done_cnt == d0 && irq_cnt == i0, "R10 no status", done_cnt - d0 + irq_cnt - i0, 0);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) len_tab[i] = 24'(i + 1);
    t_reset();
    t_single();
    t_clamp();
    t_burst();
    t_wrap();
    t_retarget();
    t_collide();
    t_noop();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R2 actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule